// File: doc/BRIEF.md
# Interrupt-Driven Power Mode Override

This block keeps the operating mode that software requests for the system. A qualifying interrupt can raise that request to a programmed target mode without software stepping in, so a system resting in a low-power mode can speed up as soon as work arrives. Modes are ordered by speed. The override takes the faster of the current request and the target, so an interrupt can never slow the system down. A status flag records that an override event happened. It stays set until software clears it.

The block also drives the bus/core clock ratio select for the clock generator. Software writes a ratio field, but the output only takes up a new value in a cycle where the actual mode, reported by the external mode sequencer, equals the requested mode. A write to a dedicated address raises a soft-reset request pulse. Software reaches the registers through a simple single-cycle write bus with a combinational read path.

Top module: `pmo_irq_override`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), req_mode is NORMAL (3), clk_ratio_sel is 0 and soft_rst_req is 0. The mode control register reads 0: override disabled, target 0, type level, status clear. The system control register reads 3 (mode NORMAL, ratio 0).
- R2: The register map and layout are as follows. Address 0, system control: bits [1:0] hold the requested mode and bits [4:2] hold the ratio field. Address 1, mode control: bit 0 enables the override, bits [2:1] hold the target mode, bit 3 selects the type (0 = level, 1 = rising edge) and bit 4 holds the status. Address 2: soft-reset trigger. Writes take effect at the clock edge of the write. reg_rdata shows the addressed register at once, and reads 0 for address 2 and any unmapped address.
- R3: When the override is enabled with level type, any irq_in bit high at a clock edge is a qualifying interrupt. At that edge req_mode becomes max(request, target) and the status bit sets.
- R4: With rising-edge type, only a bit that is high now and was low at the previous edge qualifies. An interrupt held high does not qualify again.
- R5: The override never lowers the mode. A target slower than the request leaves req_mode unchanged.
- R6: While the override is disabled, interrupts change neither req_mode nor the status bit.
- R7: The status bit stays set after the interrupt goes away. A write to the mode control register with bit 4 = 0 clears it. Writing all zeros clears the status and disables the override.
- R8: If a write to system control and a qualifying interrupt fall on the same edge, req_mode becomes max(written mode, target).
- R9: At every edge where act_mode equals req_mode, clk_ratio_sel loads the ratio field. At any other edge it holds its value.
- R10: Each write to address 2 drives soft_rst_req high for exactly the following clock cycle.
- R11: If a write to mode control and a qualifying interrupt fall on the same edge, the interrupt is judged with the old settings and the status bit ends set. The enable, target and type fields take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| irq_in | input | N_IRQ | Interrupt lines |
| act_mode | input | 2 | Actual mode reported by the mode sequencer |
| req_mode | output | 2 | Requested operating mode |
| clk_ratio_sel | output | RATIO_W | Bus/core clock ratio select |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
Two pairs of functions can land on the same edge. A software write to the mode field can meet an interrupt-driven raise, and a write to the mode control register can meet a status-setting interrupt. Directed cases drive the write strobe in the same cycle as a level interrupt or a fresh rising edge. The outcome is judged against the max-of-two rule and the set-wins status rule. Random cycles then mix writes, interrupt patterns and actual-mode values, and the bench compares every output and readback with a reference computed from the requirements.

// File: rtl/pmo_pkg.sv
// Shared constants and helpers for the power mode override block.
// Assumes modes are ordered by speed, so a larger code means a faster mode.
package pmo_pkg;
    typedef enum logic [1:0] {
        MODE_SLEEP  = 2'd0,
        MODE_DOZE   = 2'd1,
        MODE_SLOW   = 2'd2,
        MODE_NORMAL = 2'd3
    } pmode_e;

    localparam int unsigned ADDR_SYSCTL  = 0;
    localparam int unsigned ADDR_IMCTRL  = 1;
    localparam int unsigned ADDR_RSTSTAT = 2;

    // Mode control register bit positions
    localparam int unsigned IMC_EN_BIT   = 0;
    localparam int unsigned IMC_TGT_LSB  = 1;
    localparam int unsigned IMC_TYPE_BIT = 3;
    localparam int unsigned IMC_STAT_BIT = 4;

    // Returns the faster of two mode codes
    function automatic logic [1:0] faster_mode(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pmo_irq_qual.sv
// Interrupt qualification. Each line is checked either as a level or as a
// rising edge against the value seen at the previous clock edge.
// Assumes irq_in is already synchronous to clk.
module pmo_irq_qual #(
    parameter int unsigned N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             edge_sel,
    output logic             qual
);
    logic [N_IRQ-1:0] irq_q;
    logic [N_IRQ-1:0] line_hit;

    // Keep the previous sample of every line for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_in;
    end

    // Per-line qualification according to the selected type
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        assign line_hit[g] = edge_sel ? (irq_in[g] & ~irq_q[g]) : irq_in[g];
    end

    // Any qualifying line is a qualifying interrupt
    assign qual = |line_hit;
endmodule

// File: rtl/pmo_regfile.sv
// Register file: system control (mode, clock ratio), mode control (enable,
// target, type, sticky status) and the soft-reset trigger.
// Assumes DATA_W is wide enough for both register layouts.
module pmo_regfile
    import pmo_pkg::*;
#(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               hit,
    output logic [1:0]         sw_mode,
    output logic [RATIO_W-1:0] ratio,
    output logic               imc_en,
    output logic [1:0]         imc_tgt,
    output logic               imc_type,
    output logic               imc_status,
    output logic               srst_req,
    output logic [DATA_W-1:0]  rdata
);
    localparam int unsigned RATIO_LSB = 2;

    logic wr_sys;
    logic wr_imc;
    logic wr_rst;
    logic [1:0] base_mode;

    assign wr_sys = wr && (addr == ADDR_W'(ADDR_SYSCTL));
    assign wr_imc = wr && (addr == ADDR_W'(ADDR_IMCTRL));
    assign wr_rst = wr && (addr == ADDR_W'(ADDR_RSTSTAT));

    // A same-edge software write sets the base that an interrupt may raise
    assign base_mode = wr_sys ? wdata[1:0] : sw_mode;

    // System control register with the interrupt raise merged in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_mode <= MODE_NORMAL;
            ratio   <= '0;
        end else begin
            sw_mode <= hit ? faster_mode(base_mode, imc_tgt) : base_mode;
            if (wr_sys) ratio <= wdata[RATIO_LSB +: RATIO_W];
        end
    end

    // Mode control fields; the status set by an interrupt wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imc_en     <= 1'b0;
            imc_tgt    <= MODE_SLEEP;
            imc_type   <= 1'b0;
            imc_status <= 1'b0;
        end else begin
            if (wr_imc) begin
                imc_en   <= wdata[IMC_EN_BIT];
                imc_tgt  <= wdata[IMC_TGT_LSB +: 2];
                imc_type <= wdata[IMC_TYPE_BIT];
            end
            imc_status <= hit | (imc_status & (~wr_imc | wdata[IMC_STAT_BIT]));
        end
    end

    // One-cycle soft-reset request after a trigger write
    always_ff @(posedge clk) begin
        if (!rst_n) srst_req <= 1'b0;
        else        srst_req <= wr_rst;
    end

    // Combinational read mux
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_SYSCTL)) begin
            rdata[1:0]                   = sw_mode;
            rdata[RATIO_LSB +: RATIO_W]  = ratio;
        end else if (addr == ADDR_W'(ADDR_IMCTRL)) begin
            rdata[IMC_EN_BIT]            = imc_en;
            rdata[IMC_TGT_LSB +: 2]      = imc_tgt;
            rdata[IMC_TYPE_BIT]          = imc_type;
            rdata[IMC_STAT_BIT]          = imc_status;
        end
    end
endmodule

// File: rtl/pmo_ratio_gate.sv
// Clock ratio gate: the select output takes the software ratio only at an
// edge where the actual mode matches the requested mode, else it holds.
// Assumes act_mode is synchronous to clk.
module pmo_ratio_gate #(
    parameter int unsigned RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         act_mode,
    input  logic [1:0]         req_mode,
    input  logic [RATIO_W-1:0] ratio_field,
    output logic [RATIO_W-1:0] ratio_sel
);
    // Update the select only in a settled mode
    always_ff @(posedge clk) begin
        if (!rst_n)                     ratio_sel <= '0;
        else if (act_mode == req_mode)  ratio_sel <= ratio_field;
    end
endmodule

// File: rtl/pmo_irq_override.sv
// Top level: requested power mode with interrupt-driven raise, clock ratio
// select gating and soft-reset trigger. The mode sequencer and the clock
// generator sit outside; act_mode reports the sequencer's current mode.
module pmo_irq_override #(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned RATIO_W = 3,
    parameter int unsigned N_IRQ   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [N_IRQ-1:0]   irq_in,
    input  logic [1:0]         act_mode,
    output logic [1:0]         req_mode,
    output logic [RATIO_W-1:0] clk_ratio_sel,
    output logic               soft_rst_req
);
    logic               irq_qual;
    logic               irq_hit;
    logic               imc_en;
    logic [1:0]         imc_tgt;
    logic               imc_type;
    logic               imc_status;
    logic [RATIO_W-1:0] ratio_field;

    // An override event needs the enable and a qualifying interrupt
    assign irq_hit = imc_en & irq_qual;

    pmo_irq_qual #(.N_IRQ(N_IRQ)) i_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .edge_sel (imc_type),
        .qual     (irq_qual)
    );

    pmo_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .hit        (irq_hit),
        .sw_mode    (req_mode),
        .ratio      (ratio_field),
        .imc_en     (imc_en),
        .imc_tgt    (imc_tgt),
        .imc_type   (imc_type),
        .imc_status (imc_status),
        .srst_req   (soft_rst_req),
        .rdata      (reg_rdata)
    );

    pmo_ratio_gate #(.RATIO_W(RATIO_W)) i_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_mode    (act_mode),
        .req_mode    (req_mode),
        .ratio_field (ratio_field),
        .ratio_sel   (clk_ratio_sel)
    );
endmodule

// File: rtl/pmo_checker.sv
// Property checker for the power mode override, bound to the top module.
module pmo_checker
    import pmo_pkg::*;
#(
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned RATIO_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [1:0]         act_mode,
    input logic [1:0]         req_mode,
    input logic [RATIO_W-1:0] clk_ratio_sel,
    input logic               soft_rst_req,
    input logic               imc_en,
    input logic               imc_status,
    input logic               irq_hit
);
    logic wr_sys;
    logic wr_imc;
    logic wr_rst;
    assign wr_sys = reg_wr && (reg_addr == ADDR_W'(ADDR_SYSCTL));
    assign wr_imc = reg_wr && (reg_addr == ADDR_W'(ADDR_IMCTRL));
    assign wr_rst = reg_wr && (reg_addr == ADDR_W'(ADDR_RSTSTAT));

    assert_mode_no_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sys |=> req_mode >= $past(req_mode));

    assert_hit_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hit |=> imc_status);

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!imc_en && !imc_status && !wr_imc) |=> !imc_status);

    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (imc_status && !wr_imc) |=> imc_status);

    assert_ratio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode != req_mode) |=> $stable(clk_ratio_sel));

    assert_srst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rst |=> soft_rst_req);

    assert_srst_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rst |=> !soft_rst_req);
endmodule

bind pmo_irq_override pmo_checker #(.ADDR_W(ADDR_W), .RATIO_W(RATIO_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .act_mode      (act_mode),
    .req_mode      (req_mode),
    .clk_ratio_sel (clk_ratio_sel),
    .soft_rst_req  (soft_rst_req),
    .imc_en        (imc_en),
    .imc_status    (imc_status),
    .irq_hit       (irq_hit)
);

// File: tb/test_pmo_irq_override.sv
`timescale 1ns/1ps
module test_pmo_irq_override;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned RATIO_W = 3;
    localparam int unsigned N_IRQ   = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [DATA_W-1:0]  reg_wdata = '0;
    logic [DATA_W-1:0]  reg_rdata;
    logic [N_IRQ-1:0]   irq_in = '0;
    logic [1:0]         act_mode = 2'd0;
    logic [1:0]         req_mode;
    logic [RATIO_W-1:0] clk_ratio_sel;
    logic               soft_rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    pmo_irq_override #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W), .N_IRQ(N_IRQ))
    i_pmo_irq_override (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .act_mode(act_mode), .req_mode(req_mode), .clk_ratio_sel(clk_ratio_sel),
        .soft_rst_req(soft_rst_req)
    );

    // Reference state built from the requirements
    logic [1:0]         m_mode, m_tgt;
    logic [RATIO_W-1:0] m_ratio, m_sel;
    logic               m_en, m_typ, m_stat, m_srst;
    logic [N_IRQ-1:0]   m_prev;

    function automatic logic [1:0] fmax(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] v;
        v = '0;
        if (a == 0) begin v[1:0] = m_mode; v[4:2] = m_ratio; end
        else if (a == 1) begin v[0] = m_en; v[2:1] = m_tgt; v[3] = m_typ; v[4] = m_stat; end
        return v;
    endfunction

    task automatic model_reset();
        m_mode = 2'd3; m_tgt = 2'd0; m_ratio = '0; m_sel = '0;
        m_en = 1'b0; m_typ = 1'b0; m_stat = 1'b0; m_srst = 1'b0; m_prev = '0;
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive at the falling edge, step the model, compare after the next rising edge
    task automatic cycle(input string tag, input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic [N_IRQ-1:0] irq,
                         input logic [1:0] act);
        logic qual, hit, w0, w1, w2;
        logic [1:0] base;
        reg_wr = wr; reg_addr = a; reg_wdata = d; irq_in = irq; act_mode = act;
        qual = m_typ ? |(irq & ~m_prev) : |irq;
        hit  = m_en & qual;
        w0 = wr && a == 0; w1 = wr && a == 1; w2 = wr && a == 2;
        m_sel  = (act == m_mode) ? m_ratio : m_sel;
        base   = w0 ? d[1:0] : m_mode;
        m_stat = hit | (m_stat & (!w1 | d[4]));
        m_mode = hit ? fmax(base, m_tgt) : base;
        if (w0) m_ratio = d[4:2];
        if (w1) begin m_en = d[0]; m_tgt = d[2:1]; m_typ = d[3]; end
        m_srst = w2;
        m_prev = irq;
        @(posedge clk);
        @(negedge clk);
        check(tag, "req_mode", int'(req_mode), int'(m_mode));
        check(tag, "clk_ratio_sel", int'(clk_ratio_sel), int'(m_sel));
        check(tag, "soft_rst_req", int'(soft_rst_req), int'(m_srst));
        check(tag, "reg_rdata", int'(reg_rdata), int'(exp_read(a)));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #800000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, read through both registers
        check("R1", "req_mode", int'(req_mode), 3);
        check("R1", "clk_ratio_sel", int'(clk_ratio_sel), 0);
        check("R1", "soft_rst_req", int'(soft_rst_req), 0);
        reg_addr = 2'd1; #0.1;
        check("R1", "imctrl read", int'(reg_rdata), 0);
        reg_addr = 2'd0; #0.1;
        check("R1", "sysctl read", int'(reg_rdata), 3);

        // R2: mode DOZE, ratio 5; act differs so the select holds
        cycle("R2", 1, 2'd0, 8'd21, 4'h0, 2'd0);
        cycle("R2", 0, 2'd3, 8'd0, 4'h0, 2'd0);
        // R6: interrupts while disabled
        cycle("R6", 0, 2'd1, 8'd0, 4'hF, 2'd0);
        cycle("R6", 0, 2'd1, 8'd0, 4'h2, 2'd0);
        // R3: enable level type, target NORMAL, line held high
        cycle("R3", 1, 2'd1, 8'd7, 4'h2, 2'd0);
        cycle("R3", 0, 2'd1, 8'd0, 4'h2, 2'd0);
        // R7: interrupt gone, status stays; clearing write of zero
        cycle("R7", 0, 2'd1, 8'd0, 4'h0, 2'd0);
        cycle("R7", 1, 2'd1, 8'd0, 4'h0, 2'd0);
        // R5: target SLOW below a NORMAL request
        cycle("R5", 1, 2'd0, 8'd3, 4'h0, 2'd0);
        cycle("R5", 1, 2'd1, 8'd5, 4'h8, 2'd0);
        cycle("R5", 0, 2'd0, 8'd0, 4'h8, 2'd0);
        // R4: edge type, target NORMAL; held line does not retrigger
        cycle("R4", 1, 2'd1, 8'd15, 4'h0, 2'd0);
        cycle("R4", 1, 2'd0, 8'd0, 4'h0, 2'd0);
        cycle("R4", 0, 2'd0, 8'd0, 4'h1, 2'd0);
        cycle("R4", 1, 2'd0, 8'd0, 4'h1, 2'd0);
        cycle("R4", 0, 2'd0, 8'd0, 4'h1, 2'd0);
        // R8: software write of DOZE on the same edge as a fresh rise
        cycle("R8", 1, 2'd0, 8'd1, 4'h3, 2'd0);
        cycle("R8", 0, 2'd0, 8'd0, 4'h0, 2'd0);
        // R11: clearing write on the same edge as a rising edge
        cycle("R11", 0, 2'd1, 8'd0, 4'h0, 2'd0);
        cycle("R11", 1, 2'd1, 8'd0, 4'h4, 2'd0);
        cycle("R11", 0, 2'd1, 8'd0, 4'h0, 2'd0);
        // R9: ratio 6 while mismatched, then settle
        cycle("R9", 1, 2'd0, 8'd27, 4'h0, 2'd1);
        cycle("R9", 0, 2'd0, 8'd0, 4'h0, 2'd0);
        cycle("R9", 0, 2'd0, 8'd0, 4'h0, 2'd3);
        cycle("R9", 0, 2'd0, 8'd0, 4'h0, 2'd3);
        // R10: soft-reset trigger, back-to-back and single
        cycle("R10", 1, 2'd2, 8'hA5, 4'h0, 2'd3);
        cycle("R10", 1, 2'd2, 8'h00, 4'h0, 2'd3);
        cycle("R10", 0, 2'd2, 8'h00, 4'h0, 2'd3);

        // Random mix of writes, interrupts and actual modes
        for (int i = 0; i < 4000; i++) begin
            bit wr;
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            wr = ($urandom % 4) == 0;
            a  = ADDR_W'($urandom % 4);
            d  = DATA_W'($urandom);
            if (a == 1 && ($urandom % 2) == 1) d[0] = 1'b1;
            cycle("R3/R8 random", wr, a, d, N_IRQ'(($urandom % 3 == 0) ? $urandom : 0),
                  2'($urandom % 4));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule